// File: doc/BRIEF.md
# Thread Interrupt Priority Context

This block keeps the interrupt presentation state of one hardware thread. It holds a bitmap of pending priorities, a current-priority register that sets the thread's masking level, a derived pending priority that names the most favoured pending bit, and a two-bit exception-source field that records which ring raised the exception now being presented. Priority 0 is the most favoured and 7 the least. An empty bitmap yields a pending priority of 0xFF.

Four kinds of event drive the state. A notification sets one priority bit. A context push ORs a saved bitmap into the live one. A write loads the current-priority register. An acknowledge hands the most favoured pending priority to the core and retires it. A new notification only claims the exception-source field when it is more favoured than everything already pending and than the current priority. Because of that rule, a less favoured arrival can never take over an exception that has been raised but not yet acknowledged.

Top module: `tipc_ctx`

## Requirements
- R1: While reset is applied and after it is released, the bitmap is 0, the current priority is 0xFF, the pending priority is 0xFF, the exception-source field is 0 (none), and the exception line and ack_valid are low.
- R2: The pending priority equals the index of the lowest set bit of the bitmap, or 0xFF when the bitmap is empty.
- R3: A notification of priority p sets bit p of the bitmap, visible on the cycle after it is sampled.
- R4: The exception line is high exactly while the pending priority is numerically below the current priority. It follows every state change with no added delay beyond the state register.
- R5: A notification writes its ring code into the exception-source field only when its priority is below both the pre-edge pending priority and the current priority. Otherwise the field keeps its value.
- R6: A context push ORs its bitmap into the live bitmap, and the pending priority then reflects the merged bitmap.
- R7: An acknowledge returns, one cycle later with ack_valid high, the pending priority sampled at the request. It clears that bit, loads the current priority with that value and sets the exception-source field to 0. With an empty bitmap it returns 0xFF and leaves the current priority unchanged.
- R8: A current-priority write takes effect on the next cycle and re-evaluates the exception line. An acknowledge in the same cycle takes precedence over the write.
- R9: Ring codes are 0 none, 1 OS, 2 pool, 3 physical. pool_hit is high only when the field equals 2 exactly, so code 3 does not hit.
- R10: Notification, push and acknowledge in one cycle combine. The acknowledge clears only the bit of the pre-edge pending priority, and a bit set in that same cycle survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_prio | input | 3 | Notification priority |
| ntf_ring | input | 2 | Ring code of the notification |
| push_valid | input | 1 | Context-push strobe |
| push_bits | input | 8 | Saved pending bitmap to merge |
| cppr_wr | input | 1 | Current-priority write strobe |
| cppr_data | input | 8 | Current-priority write value |
| ack_req | input | 1 | Acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_prio | output | 8 | Acknowledged priority, 0xFF if none |
| irq_o | output | 1 | Exception line to the core |
| pend_bits | output | 8 | Live pending bitmap |
| cppr_o | output | 8 | Current priority |
| pipr_o | output | 8 | Pending priority |
| nsr_o | output | 2 | Exception-source ring field |
| pool_hit | output | 1 | Field equals the pool code |

## Verification
The key pattern raises a favoured notification and then sends a less favoured one before the acknowledge. It tells a design that compares against the pending priority apart from one that compares against the current priority, because the source field must stay unchanged. A context push onto a non-empty bitmap separates merging from replacing. Acknowledges issued together with notifications, pushes and priority writes separate the orderings inside one cycle. A sweep of single priorities, an acknowledge on an empty bitmap, and the physical ring code show the encoder edges, the 0xFF path and exact pool matching.

// File: rtl/tipc_pkg.sv
`timescale 1ns/1ps
package tipc_pkg;
  typedef enum logic [1:0] {
    RING_NONE = 2'b00,
    RING_OS   = 2'b01,
    RING_POOL = 2'b10,
    RING_PHYS = 2'b11
  } ring_e;
endpackage

// File: rtl/tipc_rst_sync.sv
`timescale 1ns/1ps
module tipc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/tipc_prio_enc.sv
`timescale 1ns/1ps
module tipc_prio_enc #(
  parameter int NPRIO = 8,
  parameter int PW    = 8
) (
  input  logic [NPRIO-1:0] bits,
  output logic [PW-1:0]    pipr
);
  localparam int IDXW = $clog2(NPRIO);

  logic [IDXW-1:0] idx;
  logic            found;

  // Lowest index wins: scan from the top so the last hit is the smallest.
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = NPRIO - 1; i >= 0; i--) begin
      if (bits[i]) begin
        idx   = IDXW'(i);
        found = 1'b1;
      end
    end
    pipr = found ? PW'(idx) : '1;
  end
endmodule

// File: rtl/tipc_pend_store.sv
`timescale 1ns/1ps
module tipc_pend_store #(
  parameter int NPRIO = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPRIO-1:0] set_mask,
  input  logic [NPRIO-1:0] clr_mask,
  output logic [NPRIO-1:0] bits_q
);
  logic [NPRIO-1:0] bits_d;
  logic             bits_en;

  // Per-bit next state: a set in the same cycle beats a clear.
  for (genvar g = 0; g < NPRIO; g++) begin : g_bit
    assign bits_d[g] = (bits_q[g] & ~clr_mask[g]) | set_mask[g];
  end

  assign bits_en = (|set_mask) | (|clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_mask) |=> ((bits_q & $past(set_mask)) == $past(set_mask))); // R3
endmodule

// File: rtl/tipc_ctrl.sv
`timescale 1ns/1ps
module tipc_ctrl
  import tipc_pkg::*;
#(
  parameter int NPRIO = 8,
  parameter int PW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ntf_valid,
  input  logic [$clog2(NPRIO)-1:0] ntf_prio,
  input  logic [1:0]               ntf_ring,
  input  logic                     cppr_wr,
  input  logic [PW-1:0]            cppr_data,
  input  logic                     ack_req,
  input  logic [PW-1:0]            pipr,
  output logic [NPRIO-1:0]         clr_mask,
  output logic [PW-1:0]            cppr_q,
  output ring_e                    nsr_q,
  output logic                     ack_valid,
  output logic [PW-1:0]            ack_prio,
  output logic                     irq_o
);
  localparam int IDXW = $clog2(NPRIO);

  logic          ack_hit;
  logic          ntf_better;
  logic [PW-1:0] cppr_d;
  logic          cppr_en;
  ring_e         nsr_d;
  logic          nsr_en;

  assign ack_hit    = ack_req && (pipr != '1);
  assign clr_mask   = ack_hit ? (NPRIO'(1) << pipr[IDXW-1:0]) : '0;
  // Preemption is judged against what is already pending, and the mask level.
  assign ntf_better = ntf_valid && (PW'(ntf_prio) < pipr) && (PW'(ntf_prio) < cppr_q);

  always_comb begin
    cppr_d  = cppr_q;
    cppr_en = 1'b0;
    if (ack_req) begin
      if (ack_hit) begin
        cppr_d  = pipr;
        cppr_en = 1'b1;
      end
    end else if (cppr_wr) begin
      cppr_d  = cppr_data;
      cppr_en = 1'b1;
    end
  end

  always_comb begin
    nsr_d  = nsr_q;
    nsr_en = 1'b0;
    if (ack_req) begin
      nsr_d  = RING_NONE;
      nsr_en = 1'b1;
    end else if (ntf_better) begin
      nsr_d  = ring_e'(ntf_ring);
      nsr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cppr_q <= '1;
    else if (cppr_en) cppr_q <= cppr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nsr_q <= RING_NONE;
    else if (nsr_en) nsr_q <= nsr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_valid <= 1'b0;
    else        ack_valid <= ack_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ack_prio <= '1;
    else if (ack_req) ack_prio <= pipr;
  end

  assign irq_o = (pipr < cppr_q);

  AST_ACK_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (ack_valid && ack_prio == $past(pipr))); // R7
  AST_ACK_LOADS_CPPR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && $past(1'b1) && pipr != '1) |=> (cppr_q == $past(pipr))); // R7
  AST_ACK_CLEARS_NSR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> (nsr_q == RING_NONE)); // R7
  AST_NO_DEMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ack_req && PW'(ntf_prio) >= pipr) |=> $stable(nsr_q)); // R5
  AST_CPPR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cppr_wr && !ack_req) |=> (cppr_q == $past(cppr_data))); // R8
endmodule

// File: rtl/tipc_ctx.sv
`timescale 1ns/1ps
module tipc_ctx
  import tipc_pkg::*;
#(
  parameter int NPRIO = 8,
  parameter int PW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ntf_valid,
  input  logic [$clog2(NPRIO)-1:0] ntf_prio,
  input  logic [1:0]               ntf_ring,
  input  logic                     push_valid,
  input  logic [NPRIO-1:0]         push_bits,
  input  logic                     cppr_wr,
  input  logic [PW-1:0]            cppr_data,
  input  logic                     ack_req,
  output logic                     ack_valid,
  output logic [PW-1:0]            ack_prio,
  output logic                     irq_o,
  output logic [NPRIO-1:0]         pend_bits,
  output logic [PW-1:0]            cppr_o,
  output logic [PW-1:0]            pipr_o,
  output logic [1:0]               nsr_o,
  output logic                     pool_hit
);
  logic             rst_s;
  logic [NPRIO-1:0] set_mask;
  logic [NPRIO-1:0] clr_mask;
  logic [NPRIO-1:0] bits_q;
  logic [PW-1:0]    pipr;
  ring_e            nsr_q;

  tipc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  // A push merges with the live bitmap; it never overwrites it.
  assign set_mask = (ntf_valid  ? (NPRIO'(1) << ntf_prio) : '0)
                  | (push_valid ? push_bits               : '0);

  tipc_pend_store #(.NPRIO(NPRIO)) u_store (
    .clk      (clk),
    .rst_n    (rst_s),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .bits_q   (bits_q)
  );

  tipc_prio_enc #(.NPRIO(NPRIO), .PW(PW)) u_enc (
    .bits (bits_q),
    .pipr (pipr)
  );

  tipc_ctrl #(.NPRIO(NPRIO), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s),
    .ntf_valid (ntf_valid),
    .ntf_prio  (ntf_prio),
    .ntf_ring  (ntf_ring),
    .cppr_wr   (cppr_wr),
    .cppr_data (cppr_data),
    .ack_req   (ack_req),
    .pipr      (pipr),
    .clr_mask  (clr_mask),
    .cppr_q    (cppr_o),
    .nsr_q     (nsr_q),
    .ack_valid (ack_valid),
    .ack_prio  (ack_prio),
    .irq_o     (irq_o)
  );

  assign pend_bits = bits_q;
  assign pipr_o    = pipr;
  assign nsr_o     = nsr_q;
  // Exact code match: the physical code shares a bit with pool but must not hit.
  assign pool_hit  = (nsr_q == RING_POOL);

  AST_IRQ_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_s)
    (bits_q == '0) |-> !irq_o); // R4
  AST_PUSH_MERGES: assert property (@(posedge clk) disable iff (!rst_s)
    (push_valid && !ack_req) |=> ((bits_q & $past(bits_q | push_bits)) == $past(bits_q | push_bits))); // R6
endmodule

// File: tb/sim_tipc_ctx.sv
`timescale 1ns/1ps
module sim_tipc_ctx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ntf_valid = 1'b0;
  logic [2:0] ntf_prio = '0;
  logic [1:0] ntf_ring = '0;
  logic       push_valid = 1'b0;
  logic [7:0] push_bits = '0;
  logic       cppr_wr = 1'b0;
  logic [7:0] cppr_data = '0;
  logic       ack_req = 1'b0;
  logic       ack_valid, irq_o, pool_hit;
  logic [7:0] ack_prio, pend_bits, cppr_o, pipr_o;
  logic [1:0] nsr_o;

  always #2.5 clk = ~clk;

  tipc_ctx #(.NPRIO(8), .PW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
    .ntf_ring(ntf_ring), .push_valid(push_valid), .push_bits(push_bits),
    .cppr_wr(cppr_wr), .cppr_data(cppr_data), .ack_req(ack_req),
    .ack_valid(ack_valid), .ack_prio(ack_prio), .irq_o(irq_o),
    .pend_bits(pend_bits), .cppr_o(cppr_o), .pipr_o(pipr_o), .nsr_o(nsr_o),
    .pool_hit(pool_hit)
  );

  int         n_chk = 0;
  int         n_fail = 0;
  bit         running = 1'b0;
  bit         done = 1'b0;
  logic [7:0] m_ipb = '0;
  logic [7:0] m_cppr = 8'hFF;
  logic [1:0] m_nsr = '0;
  logic [7:0] exp_q[$];

  function automatic logic [7:0] mpipr(input logic [7:0] b);
    for (int i = 0; i < 8; i++) if (b[i]) return 8'(i);
    return 8'hFF;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "bitmap", pend_bits, m_ipb);
    chk(tag, "cppr", cppr_o, m_cppr);
    chk(tag, "pipr", pipr_o, mpipr(m_ipb));
    chk(tag, "nsr", 8'(nsr_o), 8'(m_nsr));
    chk(tag, "irq", 8'(irq_o), 8'(mpipr(m_ipb) < m_cppr));
    chk(tag, "pool_hit", 8'(pool_hit), 8'(m_nsr == 2'b10));
  endtask

  // Driver: applies one cycle of stimulus, updates the model, queues ack results.
  task automatic cyc(input logic nv, input logic [2:0] np, input logic [1:0] nr,
                     input logic pv, input logic [7:0] pb,
                     input logic cw, input logic [7:0] cd,
                     input logic ak, input string tag);
    logic [7:0] p;
    logic       hit;
    p   = mpipr(m_ipb);
    hit = ak && (p != 8'hFF);
    if (ak) exp_q.push_back(p);
    if (ak) m_nsr = 2'b00;
    else if (nv && (8'(np) < p) && (8'(np) < m_cppr)) m_nsr = nr;
    if (ak) begin
      if (hit) m_cppr = p;
    end else if (cw) m_cppr = cd;
    m_ipb = (m_ipb & ~(hit ? (8'd1 << p[2:0]) : 8'd0))
          | (pv ? pb : 8'd0) | (nv ? (8'd1 << np) : 8'd0);
    ntf_valid = nv; ntf_prio = np; ntf_ring = nr;
    push_valid = pv; push_bits = pb;
    cppr_wr = cw; cppr_data = cd; ack_req = ak;
    @(negedge clk);
    ntf_valid = 1'b0; push_valid = 1'b0; cppr_wr = 1'b0; ack_req = 1'b0;
    chk_all(tag);
  endtask

  task automatic notify(input logic [2:0] p, input logic [1:0] r, input string tag);
    cyc(1'b1, p, r, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, tag);
  endtask
  task automatic push(input logic [7:0] b, input string tag);
    cyc(1'b0, 3'd0, 2'd0, 1'b1, b, 1'b0, 8'h00, 1'b0, tag);
  endtask
  task automatic wcppr(input logic [7:0] d, input string tag);
    cyc(1'b0, 3'd0, 2'd0, 1'b0, 8'h00, 1'b1, d, 1'b0, tag);
  endtask
  task automatic ack(input string tag);
    cyc(1'b0, 3'd0, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, tag);
  endtask

  // Monitor: pops expected acknowledge results as the design produces them.
  always @(negedge clk) begin
    if (running && ack_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R7 unexpected ack: actual %0h expected none", ack_prio);
      end else begin
        chk("R7 ack result", "ack_prio", ack_prio, exp_q.pop_front());
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    chk("R1 in reset", "ack_valid", 8'(ack_valid), 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    running = 1'b1;
    chk_all("R1 after release");

    wcppr(8'h05, "R8 write cppr 5");
    notify(3'd6, 2'b01, "R3 R5 notify 6 masked by cppr");
    notify(3'd3, 2'b10, "R4 R9 notify 3 pool raises");
    notify(3'd4, 2'b01, "R5 lower prio keeps pool source");
    ack("R7 ack takes 3");
    notify(3'd1, 2'b11, "R9 phys code no pool hit");
    wcppr(8'h00, "R8 cppr 0 masks irq");
    wcppr(8'hFF, "R8 cppr FF unmasks irq");
    ack("R7 ack takes 1");
    push(8'b0010_0100, "R6 push merges bitmap");
    cyc(1'b1, 3'd2, 2'b01, 1'b1, 8'h80, 1'b0, 8'h00, 1'b1, "R10 ack notify push same cycle");
    cyc(1'b0, 3'd0, 2'b00, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, "R8 ack beats cppr write");
    for (int k = 0; k < 8; k++) begin
      if (m_ipb != 8'h00) ack("R7 drain");
    end
    ack("R7 ack empty returns FF");
    wcppr(8'hFF, "R8 reopen cppr");
    for (int i = 0; i < 8; i++) begin
      notify(3'(i), 2'b01, "R2 single priority sweep");
      ack("R2 R7 sweep ack");
      wcppr(8'hFF, "R8 sweep reopen");
    end
    push(8'hA0, "R6 push into empty");
    push(8'h0A, "R6 push onto live bits");
    repeat (2) @(negedge clk);
    chk("R7 queue drained", "pending", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule